// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block derives the bit timing of a CAN node from the system clock. A prescaler divides the clock into time quanta. Each bit is built from quanta in this order: a one-quantum synchronization slot, a propagation stretch, a first phase stretch and a second phase stretch. At the end of the first phase stretch the block samples the bus. It reports the sample with a one-cycle strobe and holds the sampled level. At the start of every synchronization slot it raises a one-cycle transmit-point strobe, which the frame logic uses to launch the next bit.

Falling bus edges (recessive to dominant) keep the bit clock locked to the transmitter. While the frame controller holds the hard-sync enable high, as it does between frames, a qualifying edge restarts the bit. Inside a frame an edge instead stretches the first phase or cuts the second phase, by the phase error limited to the jump width. At most one such correction happens between two sample points. A correction lasts for the current bit only.

The two strobes are plain pulses with no back-pressure: the consumer must take each one in the cycle it appears, and the block never stalls or queues them. All configuration inputs are static registers. They are changed only while the bus is idle.

Top module: `can_bit_sync`

## Requirements
- R1: A quantum lasts (cfg_presc_i + 1) clock cycles. With no qualifying edge, sample strobes are (1 + prop + ph1 + ph2) quanta apart.
- R2: The sample strobe is one cycle long and comes (1 + prop + ph1) quanta after the transmit-point strobe. rx_bit_o takes the bus level captured at that point (0 = dominant, 1 = recessive) and changes only together with the sample strobe.
- R3: The transmit-point strobe is one cycle long and marks the start of each synchronization slot. With no edge it comes ph2 quanta after the sample strobe, and it never coincides with a sample strobe.
- R4: The bus input passes a two-stage synchronizer. An edge qualifies only when the last sample was recessive and the bus is dominant at the end of the current quantum. With the last sample dominant, no correction is made, even with hard sync enabled.
- R5: An edge in the synchronization slot makes no change to the bit length.
- R6: An edge in quantum n after the synchronization slot, within propagation or first phase (n = 1 for the first), delays the sample point by min(n, sjw) quanta.
- R7: For an edge in the second phase, let r be the number of quanta of that phase left after the edge quantum. If r <= sjw, the bit ends after the edge quantum. Otherwise the second phase is cut by sjw quanta.
- R8: With hard_sync_en_i high, a qualifying edge in any stretch makes its own quantum the synchronization slot. A full propagation plus first phase then follows before the sample, whatever the phase error.
- R9: At most one synchronization (hard or soft, including one in the synchronization slot) takes place between two sample points.
- R10: A stretch or cut applies to the current bit only. The next bit uses the programmed lengths.
- R11: After reset both strobes are low and rx_bit_o is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Bus receive level, 0 dominant |
| hard_sync_en_i | input | 1 | High selects hard synchronization for the next edge |
| cfg_presc_i | input | PRESC_W | Quantum length minus one, in clocks |
| cfg_prop_i | input | SEG_W | Propagation stretch in quanta (1..8) |
| cfg_ph1_i | input | SEG_W | First phase stretch in quanta (1..8) |
| cfg_ph2_i | input | SEG_W | Second phase stretch in quanta (1..8) |
| cfg_sjw_i | input | SJW_W | Jump width in quanta (1..4, not above either phase) |
| sample_o | output | 1 | One-cycle strobe at the sample point |
| rx_bit_o | output | 1 | Level captured at the last sample point |
| tx_point_o | output | 1 | One-cycle strobe at the start of a bit |

## Verification
Some properties are checked by assertions on every cycle. These are: the spacing of quantum ticks, that strobes appear only after a tick and never together, that the held bit moves only with a sample strobe, that a stretch or cut never exceeds the jump width, and that no more than one synchronization falls between two samples. The exact position of a corrected sample point or bit end can only be shown by the bench scenarios. It depends on where the edge lands, so each scenario places a falling edge in a chosen quantum and measures the clocks to the next strobe. Those scenarios also cover clamping, the early bit end, hard restart and the return to nominal length.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_TSEG1 = 2'd1,
    SEG_TSEG2 = 2'd2
  } seg_e;
endpackage

// File: rtl/can_tq_prescaler.sv
module can_tq_prescaler #(
  parameter int PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_i != '0 && tick_o) |=> !tick_o); // R1
endmodule

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic rx_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= rx_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], rx_i};
      end
    end
  endgenerate

  assign rx_o = chain_q[STAGES-1];
endmodule

// File: rtl/can_bit_fsm.sv
module can_bit_fsm
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             rx_i,
  input  logic             hs_en_i,
  input  logic [SEG_W-1:0] prop_i,
  input  logic [SEG_W-1:0] ph1_i,
  input  logic [SEG_W-1:0] ph2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             sample_o,
  output logic             bit_o,
  output logic             tx_point_o
);
  localparam int CNT_W = SEG_W + 2;

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] q_q, q_d;
  logic [SJW_W-1:0] ext_q, ext_d, cut_q, cut_d, adj1;
  logic             en_q, en_d, bit_d, smp_d, txp_d;
  logic             edge_ok, hard;
  logic [CNT_W-1:0] prop_w, ph1_w, ph2_w, sjw_w, ext_w, cut_w, e_pos, rem2;

  assign prop_w = CNT_W'(prop_i);
  assign ph1_w  = CNT_W'(ph1_i);
  assign ph2_w  = CNT_W'(ph2_i);
  assign sjw_w  = CNT_W'(sjw_i);
  assign e_pos  = q_q + 1'b1;
  assign rem2   = ph2_w - q_q - 1'b1;
  assign adj1   = (e_pos < sjw_w) ? SJW_W'(e_pos) : sjw_i;

  // qualifying falling edge in the quantum that ends at this tick
  assign edge_ok = tick_i && en_q && bit_o && !rx_i;
  assign hard    = edge_ok && hs_en_i;

  always_comb begin
    seg_d = seg_q;
    q_d   = q_q;
    ext_d = ext_q;
    cut_d = cut_q;
    en_d  = en_q;
    bit_d = bit_o;
    smp_d = 1'b0;
    txp_d = 1'b0;
    ext_w = CNT_W'(ext_q);
    cut_w = CNT_W'(cut_q);
    if (tick_i) begin
      if (edge_ok) en_d = 1'b0;
      unique case (seg_q)
        SEG_SYNC: begin
          seg_d = SEG_TSEG1;
          q_d   = '0;
        end
        SEG_TSEG1: begin
          if (hard) begin
            q_d   = '0;
            ext_d = '0;
          end else begin
            if (edge_ok) ext_d = adj1;
            ext_w = CNT_W'(ext_d);
            if (e_pos >= prop_w + ph1_w + ext_w) begin
              bit_d = rx_i;
              smp_d = 1'b1;
              en_d  = 1'b1;
              seg_d = SEG_TSEG2;
              q_d   = '0;
              cut_d = '0;
            end else begin
              q_d = e_pos;
            end
          end
        end
        SEG_TSEG2: begin
          if (hard) begin
            seg_d = SEG_TSEG1;
            q_d   = '0;
            ext_d = '0;
            cut_d = '0;
          end else if (edge_ok && rem2 <= sjw_w) begin
            seg_d = SEG_SYNC;
            q_d   = '0;
            ext_d = '0;
            cut_d = '0;
            txp_d = 1'b1;
          end else begin
            if (edge_ok) cut_d = sjw_i;
            cut_w = CNT_W'(cut_d);
            if (e_pos >= ph2_w - cut_w) begin
              seg_d = SEG_SYNC;
              q_d   = '0;
              ext_d = '0;
              cut_d = '0;
              txp_d = 1'b1;
            end else begin
              q_d = e_pos;
            end
          end
        end
        default: begin
          seg_d = SEG_SYNC;
          q_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q      <= SEG_SYNC;
      q_q        <= '0;
      ext_q      <= '0;
      cut_q      <= '0;
      en_q       <= 1'b1;
      bit_o      <= 1'b1;
      sample_o   <= 1'b0;
      tx_point_o <= 1'b0;
    end else begin
      seg_q      <= seg_d;
      q_q        <= q_d;
      ext_q      <= ext_d;
      cut_q      <= cut_d;
      en_q       <= en_d;
      bit_o      <= bit_d;
      sample_o   <= smp_d;
      tx_point_o <= txp_d;
    end
  end

  // synchronizations seen since the last sample point
  logic [1:0] sync_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         sync_seen_q <= '0;
    else if (smp_d)                      sync_seen_q <= '0;
    else if (edge_ok && sync_seen_q != 2'd3) sync_seen_q <= sync_seen_q + 1'b1;
  end

  AST_ONE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_seen_q <= 2'd1); // R9
  AST_EXT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q <= sjw_i); // R6
  AST_CUT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cut_q <= sjw_i); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && tx_point_o)); // R3
  AST_TX_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_point_o |-> $past(tick_i)); // R3
  AST_SAMPLE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(tick_i)); // R2
  AST_BIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_o |-> $stable(bit_o)); // R2
endmodule

// File: rtl/can_bit_sync.sv
module can_bit_sync #(
  parameter int PRESC_W     = 8,
  parameter int SEG_W       = 4,
  parameter int SJW_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_i,
  input  logic               hard_sync_en_i,
  input  logic [PRESC_W-1:0] cfg_presc_i,
  input  logic [SEG_W-1:0]   cfg_prop_i,
  input  logic [SEG_W-1:0]   cfg_ph1_i,
  input  logic [SEG_W-1:0]   cfg_ph2_i,
  input  logic [SJW_W-1:0]   cfg_sjw_i,
  output logic               sample_o,
  output logic               rx_bit_o,
  output logic               tx_point_o
);
  logic tick;
  logic rx_s;

  can_tq_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .presc_i(cfg_presc_i),
    .tick_o (tick)
  );

  can_rx_sync #(.STAGES(SYNC_STAGES)) u_rxsync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (rx_i),
    .rx_o  (rx_s)
  );

  can_bit_fsm #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .rx_i      (rx_s),
    .hs_en_i   (hard_sync_en_i),
    .prop_i    (cfg_prop_i),
    .ph1_i     (cfg_ph1_i),
    .ph2_i     (cfg_ph2_i),
    .sjw_i     (cfg_sjw_i),
    .sample_o  (sample_o),
    .bit_o     (rx_bit_o),
    .tx_point_o(tx_point_o)
  );
endmodule

// File: tb/can_bit_sync_bench.sv
module can_bit_sync_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       hs = 1'b0;
  logic [7:0] presc = 8'd3;
  logic [3:0] prop = 4'd2, ph1 = 4'd3, ph2 = 4'd3;
  logic [2:0] sjw = 3'd3;
  logic       sample, rx_bit, tx_point;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_bit_sync u_can_bit_sync (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .hard_sync_en_i(hs),
    .cfg_presc_i(presc), .cfg_prop_i(prop), .cfg_ph1_i(ph1),
    .cfg_ph2_i(ph2), .cfg_sjw_i(sjw),
    .sample_o(sample), .rx_bit_o(rx_bit), .tx_point_o(tx_point)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(input bit on_tx);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!(on_tx ? tx_point : sample) && guard < 400);
  endtask

  // start at a strobe, drive rx at chosen clock offsets, count clocks to stop strobe
  task automatic meas(input bit from_tx, input bit to_tx,
                      input int d1, input int r1, input int d2, output int c);
    wait_pulse(from_tx);
    c = 0;
    forever begin
      if (c == d1) rx = 1'b0;
      if (c == r1) rx = 1'b1;
      if (c == d2) rx = 1'b0;
      @(negedge clk);
      c++;
      if ((to_tx ? tx_point : sample) || c > 400) break;
    end
  endtask

  task automatic restore();
    rx = 1'b1;
    hs = 1'b0;
    wait_pulse(1'b0);
    wait_pulse(1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 sample low", int'(sample), 0);
    chk("R11 tx low", int'(tx_point), 0);
    chk("R11 bit recessive", int'(rx_bit), 1);
    rst_n = 1'b1;
  endtask

  task automatic t_nominal();
    int c;
    restore();
    meas(1'b0, 1'b0, -1, -1, -1, c); chk("R1 bit length", c, 36);
    meas(1'b1, 1'b0, -1, -1, -1, c); chk("R2 tx to sample", c, 24);
    meas(1'b0, 1'b1, -1, -1, -1, c); chk("R3 sample to tx", c, 12);
  endtask

  task automatic t_dominant();
    int c;
    rx = 1'b0;
    wait_pulse(1'b0);
    wait_pulse(1'b0);
    chk("R2 dominant captured", int'(rx_bit), 0);
    hs = 1'b1;
    meas(1'b0, 1'b0, -1, -1, -1, c); chk("R4 no sync after dominant", c, 36);
    restore();
  endtask

  task automatic t_sync_slot();
    int c;
    meas(1'b1, 1'b0, 0, -1, -1, c); chk("R5 edge in sync slot", c, 24);
    restore();
  endtask

  task automatic t_stretch();
    int c;
    sjw = 3'd3;
    meas(1'b1, 1'b0, 8, -1, -1, c); chk("R6 stretch by error", c, 32);
    meas(1'b1, 1'b0, -1, -1, -1, c); chk("R10 next bit nominal", c, 24);
    restore();
    meas(1'b1, 1'b0, 20, -1, -1, c); chk("R6 stretch clamped", c, 36);
    restore();
  endtask

  task automatic t_single();
    int c;
    sjw = 3'd3;
    meas(1'b1, 1'b0, 8, 12, 16, c); chk("R9 second edge ignored", c, 32);
    restore();
  endtask

  task automatic t_shrink();
    int c;
    ph2 = 4'd4;
    sjw = 3'd2;
    restore();
    meas(1'b0, 1'b1, 0, -1, -1, c); chk("R7 cut by sjw", c, 8);
    restore();
    meas(1'b0, 1'b1, 8, -1, -1, c); chk("R7 early end", c, 12);
    restore();
    meas(1'b0, 1'b1, 12, -1, -1, c); chk("R7 last quantum", c, 16);
    restore();
  endtask

  task automatic t_hard();
    int c;
    ph2 = 4'd4;
    sjw = 3'd1;
    restore();
    hs = 1'b1;
    meas(1'b1, 1'b0, 12, -1, -1, c); chk("R8 hard in first stretch", c, 36);
    restore();
    hs = 1'b1;
    meas(1'b0, 1'b0, 4, -1, -1, c); chk("R8 hard in second phase", c, 28);
    restore();
    ph2 = 4'd3;
    sjw = 3'd3;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nominal();
    t_dominant();
    t_sync_slot();
    t_stretch();
    t_single();
    t_shrink();
    t_hard();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule